// File: doc/BRIEF.md
# Host Command Port (serial or byte-wide)

This block is the slave end of the link between an external 4- or 8-bit microcontroller and a signal-processing core. The host sends 16-bit command words and collects 16-bit result words. A static mode pin picks one of two physical forms. The first is a serial form with one clock and data pair for each direction, both clocked by the host. The second is a byte-wide form with read and write strobes, a half-select input and an 8-bit data path.

On the core side the port holds a command register with a ready flag and a one-cycle interrupt. It also holds a result register that the core loads. The result-waiting output goes low when a result is loaded and returns high once the host has taken the whole word. All host inputs pass through a synchronizer into the system clock domain, and the port acts on the strobe edges that the synchronizer reports.

Top module: `host_cmd_port`

## Requirements
- R1: The mode pin selects the form: 1 means serial and 0 means byte-wide. The strobes of the form that is not selected have no effect on the command register, the ready flag or the result-waiting output.
- R2: In serial mode, `ser_wdat` is taken at each falling edge of `ser_wclk`, least significant bit first. The sixteenth falling edge loads the assembled word into `cmd_word`.
- R3: Each completed command sets `cmd_ready` and raises `cmd_irq` for exactly one cycle, in the same cycle that `cmd_word` takes the new value.
- R4: A `cmd_take` pulse clears `cmd_ready` on the next clock. If a command completes in the same cycle as `cmd_take`, the completion wins and `cmd_ready` stays set.
- R5: A `res_wr` pulse stores `res_word` and drives `res_wait_n` low from the next clock.
- R6: In serial mode, `ser_rdat` presents result bit 0 before the first falling edge of `ser_rclk`. It advances one bit after each falling edge, least significant bit first. `res_wait_n` stays low through fifteen falls and goes high after the sixteenth.
- R7: In byte-wide mode, a write strobe with `par_hi_sel`=0 stores the low byte. A write strobe with `par_hi_sel`=1 stores the high byte and completes the command {high, low}.
- R8: In byte-wide mode, `par_dout` shows result bits 7:0 when `par_hi_sel`=0 and bits 15:8 when it is 1. Only a read strobe with `par_hi_sel`=1 sets `res_wait_n` high.
- R9: After reset, `cmd_ready`=0, `cmd_irq`=0, `res_wait_n`=1 and `cmd_word`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_serial | input | 1 | 1 selects the serial form, 0 the byte-wide form; static |
| ser_wclk | input | 1 | Serial command clock from the host; idles low |
| ser_wdat | input | 1 | Serial command data, sampled at falling edges |
| ser_rclk | input | 1 | Serial result clock from the host; idles low |
| ser_rdat | output | 1 | Serial result data, LSB first |
| par_wr_n | input | 1 | Byte-wide write strobe, active low |
| par_rd_n | input | 1 | Byte-wide read strobe, active low |
| par_hi_sel | input | 1 | 0 selects the low byte, 1 the high byte |
| par_din | input | 8 | Byte-wide write data |
| par_dout | output | 8 | Byte-wide read data |
| res_wait_n | output | 1 | Low while a result waits for the host |
| cmd_word | output | 16 | Last completed command |
| cmd_ready | output | 1 | Command waiting for the core |
| cmd_irq | output | 1 | One-cycle pulse when a command completes |
| cmd_take | input | 1 | Core has read the command |
| res_wr | input | 1 | Core loads a result |
| res_word | input | 16 | Result value |

## Verification
Command completion and the core's take strobe can land on the same clock edge, and the ready flag must then stay set. The bench provokes this by holding `cmd_take` high for a whole serial transfer, so the take is active when the last falling edge is detected. The monitor judges the case at the interrupt cycle: it requires `cmd_ready` to read 1 alongside the new word. The bench then requires the flag to be clear once the take is released.

// File: rtl/hcp_pkg.sv
package hcp_pkg;
  localparam int unsigned HCP_WORD_W = 16;
  typedef enum logic {HALF_LO = 1'b0, HALF_HI = 1'b1} hcp_half_e;
endpackage

// File: rtl/hcp_sync.sv
// Multi-stage synchronizer for a bundle of slow host inputs.
module hcp_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= {stg_q[STAGES-2:0], d};
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hcp_ser_rx.sv
// Serial command deserializer, LSB first, W bits per word.
module hcp_ser_rx #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word_nxt,
  output logic         done
);
  localparam int unsigned CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    word_nxt = {bit_in, sh_q[W-1:1]};
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    done     = 1'b0;
    if (shift_en) begin
      sh_d = word_nxt;
      if (cnt_q == LAST) begin
        done  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/hcp_ser_tx.sv
// Serial result serializer, LSB first; a load restarts the word.
module hcp_ser_tx #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift_en,
  output logic         bit_out,
  output logic         done
);
  localparam int unsigned CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    done  = 1'b0;
    if (load) begin
      sh_d  = load_word;
      cnt_d = '0;
    end else if (shift_en) begin
      sh_d = {1'b0, sh_q[W-1:1]};
      if (cnt_q == LAST) begin
        done  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign bit_out = sh_q[0];
endmodule

// File: rtl/host_cmd_port.sv
module host_cmd_port
  import hcp_pkg::*;
#(
  parameter int unsigned WORD_W      = HCP_WORD_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_serial,
  input  logic                ser_wclk,
  input  logic                ser_wdat,
  input  logic                ser_rclk,
  output logic                ser_rdat,
  input  logic                par_wr_n,
  input  logic                par_rd_n,
  input  logic                par_hi_sel,
  input  logic [WORD_W/2-1:0] par_din,
  output logic [WORD_W/2-1:0] par_dout,
  output logic                res_wait_n,
  output logic [WORD_W-1:0]   cmd_word,
  output logic                cmd_ready,
  output logic                cmd_irq,
  input  logic                cmd_take,
  input  logic                res_wr,
  input  logic [WORD_W-1:0]   res_word
);
  localparam int unsigned BYTE_W = WORD_W / 2;
  localparam int unsigned SYNC_W = BYTE_W + 6;
  // layout: {din, hi_sel, rd_n, wr_n, rclk, wdat, wclk}; strobes idle inactive
  localparam logic [SYNC_W-1:0] SYNC_RST = {{BYTE_W{1'b0}}, 6'b011000};

  logic [SYNC_W-1:0] s_vec;
  logic              s_wclk, s_wdat, s_rclk, s_wr_n, s_rd_n;
  hcp_half_e         s_half;
  logic [BYTE_W-1:0] s_din;

  hcp_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({par_din, par_hi_sel, par_rd_n, par_wr_n, ser_rclk, ser_wdat, ser_wclk}),
    .q     (s_vec)
  );

  assign s_wclk = s_vec[0];
  assign s_wdat = s_vec[1];
  assign s_rclk = s_vec[2];
  assign s_wr_n = s_vec[3];
  assign s_rd_n = s_vec[4];
  assign s_half = hcp_half_e'(s_vec[5]);
  assign s_din  = s_vec[SYNC_W-1:6];

  // previous synchronized strobe levels: {rd_n, wr_n, rclk, wclk}
  logic [3:0] edg_q, edg_d;
  logic       wclk_fall, rclk_fall, wr_fall, rd_fall;

  assign edg_d     = {s_rd_n, s_wr_n, s_rclk, s_wclk};
  assign wclk_fall = edg_q[0] & ~s_wclk;
  assign rclk_fall = edg_q[1] & ~s_rclk;
  assign wr_fall   = edg_q[2] & ~s_wr_n;
  assign rd_fall   = edg_q[3] & ~s_rd_n;

  logic ser_mode;
  assign ser_mode = mode_serial;

  // state
  logic [WORD_W-1:0] cmd_q, cmd_d, res_q, res_d;
  logic [BYTE_W-1:0] lo_q, lo_d;
  logic              rdy_q, rdy_d, irq_q, irq_d, pend_q, pend_d;

  logic [WORD_W-1:0] rx_word;
  logic              rx_done, tx_done, tx_bit;

  hcp_ser_rx #(.W(WORD_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (ser_mode & wclk_fall),
    .bit_in   (s_wdat),
    .word_nxt (rx_word),
    .done     (rx_done)
  );

  hcp_ser_tx #(.W(WORD_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (res_wr),
    .load_word (res_word),
    .shift_en  (ser_mode & rclk_fall & pend_q),
    .bit_out   (tx_bit),
    .done      (tx_done)
  );

  logic              pw_fall, pr_fall, cmd_done, rd_done;
  logic [WORD_W-1:0] cmd_nxt;

  assign pw_fall  = ~ser_mode & wr_fall;
  assign pr_fall  = ~ser_mode & rd_fall & pend_q;
  assign cmd_done = ser_mode ? rx_done : (pw_fall & (s_half == HALF_HI));
  assign cmd_nxt  = ser_mode ? rx_word : {s_din, lo_q};
  assign rd_done  = ser_mode ? (tx_done & pend_q) : (pr_fall & (s_half == HALF_HI));

  always_comb begin
    lo_d   = lo_q;
    cmd_d  = cmd_q;
    res_d  = res_q;
    rdy_d  = rdy_q;
    pend_d = pend_q;
    irq_d  = cmd_done;
    if (pw_fall && (s_half == HALF_LO)) lo_d = s_din;
    if (cmd_done)      cmd_d = cmd_nxt;
    if (res_wr)        res_d = res_word;
    // completion has priority over the core's take
    if (cmd_done)      rdy_d = 1'b1;
    else if (cmd_take) rdy_d = 1'b0;
    // a new result has priority over the end of a read
    if (res_wr)        pend_d = 1'b1;
    else if (rd_done)  pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edg_q  <= 4'b1100;
      lo_q   <= '0;
      cmd_q  <= '0;
      res_q  <= '0;
      rdy_q  <= 1'b0;
      irq_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      edg_q  <= edg_d;
      lo_q   <= lo_d;
      cmd_q  <= cmd_d;
      res_q  <= res_d;
      rdy_q  <= rdy_d;
      irq_q  <= irq_d;
      pend_q <= pend_d;
    end
  end

  assign cmd_word   = cmd_q;
  assign cmd_ready  = rdy_q;
  assign cmd_irq    = irq_q;
  assign res_wait_n = ~pend_q;
  assign ser_rdat   = tx_bit;
  assign par_dout   = par_hi_sel ? res_q[WORD_W-1:BYTE_W] : res_q[BYTE_W-1:0];
endmodule

// File: rtl/hcp_checker.sv
module hcp_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_irq,
  input logic         cmd_ready,
  input logic         cmd_take,
  input logic [W-1:0] cmd_word,
  input logic         res_wr,
  input logic         res_wait_n
);
  AST_IRQ_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_irq |-> cmd_ready); // R3

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_irq |=> !cmd_irq); // R3

  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && cmd_take) |=> (!cmd_ready || cmd_irq)); // R4

  AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_irq |-> $stable(cmd_word)); // R2

  AST_RESULT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr |=> !res_wait_n); // R5

  AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_wait_n) |-> !$past(res_wr)); // R6
endmodule

bind host_cmd_port hcp_checker #(.W(WORD_W)) u_hcp_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_irq    (cmd_irq),
  .cmd_ready  (cmd_ready),
  .cmd_take   (cmd_take),
  .cmd_word   (cmd_word),
  .res_wr     (res_wr),
  .res_wait_n (res_wait_n)
);

// File: tb/host_cmd_port_tb_top.sv
module host_cmd_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_HOST  = 3;

  logic        clk, rst_n;
  logic        mode_serial, ser_wclk, ser_wdat, ser_rclk, ser_rdat;
  logic        par_wr_n, par_rd_n, par_hi_sel;
  logic [7:0]  par_din, par_dout;
  logic        res_wait_n, cmd_ready, cmd_irq, cmd_take, res_wr;
  logic [15:0] cmd_word, res_word;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  host_cmd_port dut_i (
    .clk(clk), .rst_n(rst_n), .mode_serial(mode_serial),
    .ser_wclk(ser_wclk), .ser_wdat(ser_wdat), .ser_rclk(ser_rclk), .ser_rdat(ser_rdat),
    .par_wr_n(par_wr_n), .par_rd_n(par_rd_n), .par_hi_sel(par_hi_sel),
    .par_din(par_din), .par_dout(par_dout), .res_wait_n(res_wait_n),
    .cmd_word(cmd_word), .cmd_ready(cmd_ready), .cmd_irq(cmd_irq),
    .cmd_take(cmd_take), .res_wr(res_wr), .res_word(res_word)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clk_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      chk(1'b0, "watchdog", 32'(cyc), 32'd0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // monitor: each interrupt must deliver the next expected command
  always @(negedge clk) begin
    if (rst_n && cmd_irq) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected command", {16'd0, cmd_word}, 32'd0);
      end else begin
        logic [15:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(cmd_word == e, t, {16'd0, cmd_word}, {16'd0, e});
        chk(cmd_ready == 1'b1, "R3 ready with irq", {31'd0, cmd_ready}, 32'd1);
      end
    end
  end

  task automatic ser_send(input logic [15:0] w);
    exp_q.push_back(w);
    tag_q.push_back("R2 serial command");
    for (int i = 0; i < 16; i++) begin
      ser_wdat = w[i];
      ser_wclk = 1'b1;
      clk_n(HALF_HOST);
      ser_wclk = 1'b0;
      clk_n(HALF_HOST);
    end
    clk_n(5);
  endtask

  task automatic ser_recv(input logic [15:0] e);
    for (int i = 0; i < 16; i++) begin
      ser_rclk = 1'b1;
      clk_n(HALF_HOST);
      chk(ser_rdat == e[i], "R6 serial result bit", {31'd0, ser_rdat}, {31'd0, e[i]});
      if (i == 15) chk(res_wait_n == 1'b0, "R6 still waiting after 15 falls", {31'd0, res_wait_n}, 32'd0);
      ser_rclk = 1'b0;
      clk_n(HALF_HOST);
    end
    clk_n(5);
    chk(res_wait_n == 1'b1, "R6 released after 16 falls", {31'd0, res_wait_n}, 32'd1);
  endtask

  task automatic par_write(input logic [15:0] w);
    exp_q.push_back(w);
    tag_q.push_back("R7 byte-wide command");
    par_hi_sel = 1'b0; par_din = w[7:0]; par_wr_n = 1'b0;
    clk_n(4); par_wr_n = 1'b1; clk_n(3);
    par_hi_sel = 1'b1; par_din = w[15:8]; par_wr_n = 1'b0;
    clk_n(4); par_wr_n = 1'b1; clk_n(5);
  endtask

  task automatic par_read(input logic [15:0] e);
    par_hi_sel = 1'b0; par_rd_n = 1'b0; clk_n(4);
    chk(par_dout == e[7:0], "R8 low byte", {24'd0, par_dout}, {24'd0, e[7:0]});
    par_rd_n = 1'b1; clk_n(5);
    chk(res_wait_n == 1'b0, "R8 low byte keeps waiting", {31'd0, res_wait_n}, 32'd0);
    par_hi_sel = 1'b1; par_rd_n = 1'b0; clk_n(4);
    chk(par_dout == e[15:8], "R8 high byte", {24'd0, par_dout}, {24'd0, e[15:8]});
    par_rd_n = 1'b1; clk_n(5);
    chk(res_wait_n == 1'b1, "R8 released after high byte", {31'd0, res_wait_n}, 32'd1);
  endtask

  task automatic load_result(input logic [15:0] r);
    res_word = r; res_wr = 1'b1;
    clk_n(1);
    res_wr = 1'b0;
    chk(res_wait_n == 1'b0, "R5 result waiting", {31'd0, res_wait_n}, 32'd0);
  endtask

  task automatic take_cmd();
    cmd_take = 1'b1; clk_n(1); cmd_take = 1'b0; clk_n(1);
    chk(cmd_ready == 1'b0, "R4 take clears ready", {31'd0, cmd_ready}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; mode_serial = 1'b1;
    ser_wclk = 1'b0; ser_wdat = 1'b0; ser_rclk = 1'b0;
    par_wr_n = 1'b1; par_rd_n = 1'b1; par_hi_sel = 1'b0; par_din = '0;
    cmd_take = 1'b0; res_wr = 1'b0; res_word = '0;
    clk_n(4);
    // R9 reset state
    chk(cmd_ready == 1'b0 && cmd_irq == 1'b0, "R9 flags in reset", {30'd0, cmd_ready, cmd_irq}, 32'd0);
    chk(res_wait_n == 1'b1, "R9 not waiting in reset", {31'd0, res_wait_n}, 32'd1);
    chk(cmd_word == 16'd0, "R9 word in reset", {16'd0, cmd_word}, 32'd0);
    rst_n = 1'b1;
    clk_n(3);

    // R2/R3: serial commands with distinct patterns
    ser_send(16'hA5C3);
    chk(cmd_ready == 1'b1, "R3 ready after serial command", {31'd0, cmd_ready}, 32'd1);
    take_cmd();
    ser_send(16'h8001);
    take_cmd();
    ser_send(16'hFFFF);
    take_cmd();

    // R4: completion coinciding with a held take
    cmd_take = 1'b1;
    ser_send(16'h1234);
    cmd_take = 1'b0;
    clk_n(1);
    chk(cmd_ready == 1'b0, "R4 cleared after held take", {31'd0, cmd_ready}, 32'd0);

    // R5/R6: serial result read
    load_result(16'hC35A);
    ser_recv(16'hC35A);
    load_result(16'h0001);
    ser_recv(16'h0001);

    // R1: byte-wide strobes ignored in serial mode
    load_result(16'h7E81);
    par_hi_sel = 1'b1; par_din = 8'h55;
    for (int k = 0; k < 2; k++) begin
      par_wr_n = 1'b0; par_rd_n = 1'b0; clk_n(4);
      par_wr_n = 1'b1; par_rd_n = 1'b1; clk_n(4);
    end
    clk_n(4);
    chk(cmd_ready == 1'b0, "R1 byte write ignored in serial mode", {31'd0, cmd_ready}, 32'd0);
    chk(res_wait_n == 1'b0, "R1 byte read ignored in serial mode", {31'd0, res_wait_n}, 32'd0);
    ser_recv(16'h7E81);

    // byte-wide mode
    mode_serial = 1'b0;
    clk_n(4);
    par_write(16'hBEEF);
    take_cmd();
    par_write(16'h00FF);
    take_cmd();
    load_result(16'h9A3C);
    par_read(16'h9A3C);

    // R1: serial clocks ignored in byte-wide mode
    load_result(16'h4242);
    for (int k = 0; k < 16; k++) begin
      ser_wdat = 1'b1; ser_wclk = 1'b1; ser_rclk = 1'b1; clk_n(HALF_HOST);
      ser_wclk = 1'b0; ser_rclk = 1'b0; clk_n(HALF_HOST);
    end
    clk_n(5);
    chk(cmd_ready == 1'b0, "R1 serial write ignored in byte mode", {31'd0, cmd_ready}, 32'd0);
    chk(cmd_word == 16'h00FF, "R1 word unchanged in byte mode", {16'd0, cmd_word}, 32'h00FF);
    chk(res_wait_n == 1'b0, "R1 serial read ignored in byte mode", {31'd0, res_wait_n}, 32'd0);
    par_read(16'h4242);

    clk_n(5);
    chk(exp_q.size() == 0, "R2 all commands delivered", 32'(exp_q.size()), 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule